// File: doc/BRIEF.md
# Retirement-Gated Load Issue Stage

This block sits between a processor's load queue and its data memory port and decides the cycle in which each pending load may go out. A load whose address lies in ordinary memory may be sent before the instruction that produced it has retired. A load whose address lies in the side-effecting device window is held until the retire strobe reports its ID. Reading a device register can change that register's contents, so a wrong-path read of this kind must never reach the bus.

Loads leave strictly in the order in which they were enqueued. The queue holds a small number of entries. Its oldest entry is the only candidate for issue, so a held device load also holds every younger load behind it. A flush drops every entry that has not been marked retired, in the same cycle. Entries that have already retired survive the flush and are issued later.

The issue control is a two-state machine. In `ST_IDLE` the oldest entry is offered on the memory request port when it is eligible. The transition *send* (request accepted) moves to `ST_WAIT`. In `ST_WAIT` no new request is offered. The transition *return* (memory response valid) delivers the response, tagged with the ID of the outstanding load, and goes back to `ST_IDLE`.

Top module: `periph_load_gate`

## Requirements
- R1: After reset the queue is empty, `mem_req_valid_o` and `load_rsp_valid_o` are 0, and `enq_ready_o` is 1.
- R2: A load to ordinary memory at the queue head is requested in the cycle after it is enqueued, with no retire needed. Only one request is outstanding at a time: after the request handshake, `mem_req_valid_o` is 0 until the response returns.
- R3: An address belongs to the device window exactly when `(addr & PERIPH_MASK) == PERIPH_BASE`. The defaults are 0xF000_0000 / 0xF000_0000, which puts every address with top nibble 0xF in the window.
- R4: A device load is never requested before a retire strobe carrying its ID has been sampled. The strobe may arrive in the enqueue cycle or in any later cycle. The request is offered in the cycle after the strobe.
- R5: Requests leave in enqueue order. A held device load at the head blocks every younger load. While `mem_req_ready_i` is low, an offered request stays valid with the same ID and address.
- R6: The queue holds 4 entries. With 4 entries held, `enq_ready_o` is 0, and a load offered at that time is not stored.
- R7: While `flush_i` is 1, `mem_req_valid_o` is 0, and every entry without the retired mark is dropped at that edge. A dropped device load is never requested, even if its ID is retired afterwards.
- R8: Entries marked retired before a flush survive it and are issued afterwards.
- R9: `load_rsp_valid_o` follows `mem_rsp_valid_i` only while a request is outstanding. It carries that load's ID on `load_rsp_id_o` and the memory data unchanged. A response while nothing is outstanding is ignored.
- R10: While `flush_i` is 1, `enq_ready_o` is 0, and the offered load is not stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| enq_valid_i | input | 1 | A load is offered to the queue |
| enq_id_i | input | ID_W | Instruction ID of the offered load |
| enq_addr_i | input | ADDR_W | Address of the offered load |
| enq_ready_o | output | 1 | Queue accepts the offered load this cycle |
| ret_valid_i | input | 1 | An instruction retires this cycle |
| ret_id_i | input | ID_W | ID of the retiring instruction |
| flush_i | input | 1 | Discard all unretired queue entries |
| mem_req_valid_o | output | 1 | Load request to memory is valid |
| mem_req_ready_i | input | 1 | Memory accepts the request |
| mem_req_addr_o | output | ADDR_W | Request address |
| mem_req_id_o | output | ID_W | ID of the requested load |
| mem_rsp_valid_i | input | 1 | Memory returns read data |
| mem_rsp_data_i | input | DATA_W | Returned read data |
| load_rsp_valid_o | output | 1 | Completed load result is valid |
| load_rsp_id_o | output | ID_W | ID of the completed load |
| load_rsp_data_o | output | DATA_W | Data of the completed load |

## Verification
The hardest case to reach from the ports is a flush that falls while a retired device load is stalled at the head, with unretired device and ordinary loads queued behind it. The bench builds this case on purpose. It enqueues a device load together with its own retire strobe and holds memory ready low so the request stays pending. It then enqueues the younger loads and raises flush while also offering one more load. After the flush it confirms that only the retired load comes out. It then retires the flushed device load's ID and confirms that no request appears. A sweep over all sixteen top-nibble values at two low offsets checks that each address is classified into the device window or ordinary memory as R3 requires.

// File: rtl/plg_pkg.sv
package plg_pkg;
    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_WAIT = 1'b1
    } issue_state_e;
endpackage

// File: rtl/plg_region_match.sv
module plg_region_match #(
    parameter int              ADDR_W = 32,
    parameter logic [ADDR_W-1:0] BASE = '0,
    parameter logic [ADDR_W-1:0] MASK = '0
) (
    input  logic [ADDR_W-1:0] addr_i,
    output logic              hit_o
);
    // Device window membership: masked address equals the base value.
    assign hit_o = ((addr_i & MASK) == BASE);
endmodule

// File: rtl/plg_load_queue.sv
module plg_load_queue #(
    parameter int DEPTH  = 4,
    parameter int ID_W   = 3,
    parameter int ADDR_W = 32
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              enq_fire_i,
    input  logic [ID_W-1:0]   enq_id_i,
    input  logic [ADDR_W-1:0] enq_addr_i,
    input  logic              enq_periph_i,
    input  logic              ret_valid_i,
    input  logic [ID_W-1:0]   ret_id_i,
    input  logic              flush_i,
    input  logic              pop_i,
    output logic              head_valid_o,
    output logic [ID_W-1:0]   head_id_o,
    output logic [ADDR_W-1:0] head_addr_o,
    output logic              head_periph_o,
    output logic              head_ret_o,
    output logic              full_o
);
    localparam int CNT_W = $clog2(DEPTH + 1);

    logic [DEPTH-1:0]  v_q, v_n, r_q, r_n, p_q, p_n, ret_hit;
    logic [ID_W-1:0]   id_q   [DEPTH];
    logic [ID_W-1:0]   id_n   [DEPTH];
    logic [ADDR_W-1:0] addr_q [DEPTH];
    logic [ADDR_W-1:0] addr_n [DEPTH];
    logic [CNT_W-1:0]  wr_pos;
    logic              enq_ret;

    // Per-slot retire match.
    for (genvar g = 0; g < DEPTH; g++) begin : g_slot_match
        assign ret_hit[g] = ret_valid_i && v_q[g] && (id_q[g] == ret_id_i);
    end

    // A load retiring in its own enqueue cycle enters already marked.
    assign enq_ret = ret_valid_i && (ret_id_i == enq_id_i);

    always_comb begin
        v_n    = v_q;
        r_n    = r_q | ret_hit;
        p_n    = p_q;
        wr_pos = '0;
        for (int i = 0; i < DEPTH; i++) begin
            id_n[i]   = id_q[i];
            addr_n[i] = addr_q[i];
        end
        // Head leaves: everything moves one slot toward the head.
        if (pop_i) begin
            for (int i = 0; i < DEPTH - 1; i++) begin
                v_n[i]    = v_n[i+1];
                r_n[i]    = r_n[i+1];
                p_n[i]    = p_n[i+1];
                id_n[i]   = id_n[i+1];
                addr_n[i] = addr_n[i+1];
            end
            v_n[DEPTH-1] = 1'b0;
            r_n[DEPTH-1] = 1'b0;
        end
        for (int i = 0; i < DEPTH; i++) begin
            wr_pos = wr_pos + CNT_W'(v_n[i]);
        end
        if (flush_i) begin
            // Retirement is in order, so survivors form a prefix.
            v_n = v_n & r_n;
        end else if (enq_fire_i) begin
            for (int i = 0; i < DEPTH; i++) begin
                if (CNT_W'(i) == wr_pos) begin
                    v_n[i]    = 1'b1;
                    r_n[i]    = enq_ret;
                    p_n[i]    = enq_periph_i;
                    id_n[i]   = enq_id_i;
                    addr_n[i] = enq_addr_i;
                end
            end
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            v_q <= '0;
            r_q <= '0;
            p_q <= '0;
        end else begin
            v_q <= v_n;
            r_q <= r_n;
            p_q <= p_n;
        end
    end

    always_ff @(posedge clk_i) begin
        for (int i = 0; i < DEPTH; i++) begin
            id_q[i]   <= id_n[i];
            addr_q[i] <= addr_n[i];
        end
    end

    assign head_valid_o  = v_q[0];
    assign head_id_o     = id_q[0];
    assign head_addr_o   = addr_q[0];
    assign head_periph_o = p_q[0];
    assign head_ret_o    = r_q[0];
    assign full_o        = v_q[DEPTH-1];
endmodule

// File: rtl/periph_load_gate.sv
module periph_load_gate
    import plg_pkg::*;
#(
    parameter int                ADDR_W      = 32,
    parameter int                ID_W        = 3,
    parameter int                DATA_W      = 32,
    parameter int                DEPTH       = 4,
    parameter logic [ADDR_W-1:0] PERIPH_BASE = ADDR_W'(32'hF000_0000),
    parameter logic [ADDR_W-1:0] PERIPH_MASK = ADDR_W'(32'hF000_0000)
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              enq_valid_i,
    input  logic [ID_W-1:0]   enq_id_i,
    input  logic [ADDR_W-1:0] enq_addr_i,
    output logic              enq_ready_o,
    input  logic              ret_valid_i,
    input  logic [ID_W-1:0]   ret_id_i,
    input  logic              flush_i,
    output logic              mem_req_valid_o,
    input  logic              mem_req_ready_i,
    output logic [ADDR_W-1:0] mem_req_addr_o,
    output logic [ID_W-1:0]   mem_req_id_o,
    input  logic              mem_rsp_valid_i,
    input  logic [DATA_W-1:0] mem_rsp_data_i,
    output logic              load_rsp_valid_o,
    output logic [ID_W-1:0]   load_rsp_id_o,
    output logic [DATA_W-1:0] load_rsp_data_o
);
    issue_state_e      state_q, state_d;
    logic              enq_periph, enq_fire, req_fire, full;
    logic              head_valid, head_periph, head_ret, head_eligible;
    logic [ID_W-1:0]   head_id, out_id_q;
    logic [ADDR_W-1:0] head_addr;

    plg_region_match #(
        .ADDR_W (ADDR_W),
        .BASE   (PERIPH_BASE),
        .MASK   (PERIPH_MASK)
    ) u_region (
        .addr_i (enq_addr_i),
        .hit_o  (enq_periph)
    );

    assign enq_ready_o = !full && !flush_i;
    assign enq_fire    = enq_valid_i && enq_ready_o;
    assign req_fire    = mem_req_valid_o && mem_req_ready_i;

    plg_load_queue #(
        .DEPTH  (DEPTH),
        .ID_W   (ID_W),
        .ADDR_W (ADDR_W)
    ) u_queue (
        .clk_i         (clk_i),
        .rst_ni        (rst_ni),
        .enq_fire_i    (enq_fire),
        .enq_id_i      (enq_id_i),
        .enq_addr_i    (enq_addr_i),
        .enq_periph_i  (enq_periph),
        .ret_valid_i   (ret_valid_i),
        .ret_id_i      (ret_id_i),
        .flush_i       (flush_i),
        .pop_i         (req_fire),
        .head_valid_o  (head_valid),
        .head_id_o     (head_id),
        .head_addr_o   (head_addr),
        .head_periph_o (head_periph),
        .head_ret_o    (head_ret),
        .full_o        (full)
    );

    // Ordinary loads go speculatively; device loads wait for the retire mark.
    assign head_eligible = head_valid && (!head_periph || head_ret);

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            state_q  <= ST_IDLE;
            out_id_q <= '0;
        end else begin
            state_q <= state_d;
            if (req_fire) out_id_q <= head_id;
        end
    end

    // Transitions: send (ST_IDLE -> ST_WAIT), return (ST_WAIT -> ST_IDLE).
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (req_fire)        state_d = ST_WAIT;
            ST_WAIT: if (mem_rsp_valid_i) state_d = ST_IDLE;
            default:                      state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        mem_req_valid_o  = 1'b0;
        load_rsp_valid_o = 1'b0;
        unique case (state_q)
            ST_IDLE: mem_req_valid_o  = head_eligible && !flush_i;
            ST_WAIT: load_rsp_valid_o = mem_rsp_valid_i;
            default: ;
        endcase
    end

    assign mem_req_addr_o  = head_addr;
    assign mem_req_id_o    = head_id;
    assign load_rsp_id_o   = out_id_q;
    assign load_rsp_data_o = mem_rsp_data_i;
endmodule

// File: rtl/plg_checker.sv
module plg_checker #(
    parameter int                ADDR_W      = 32,
    parameter int                ID_W        = 3,
    parameter logic [ADDR_W-1:0] PERIPH_BASE = '0,
    parameter logic [ADDR_W-1:0] PERIPH_MASK = '0
) (
    input logic              clk_i,
    input logic              rst_ni,
    input logic              enq_valid_i,
    input logic [ID_W-1:0]   enq_id_i,
    input logic              enq_ready_o,
    input logic              ret_valid_i,
    input logic [ID_W-1:0]   ret_id_i,
    input logic              flush_i,
    input logic              mem_req_valid_o,
    input logic              mem_req_ready_i,
    input logic [ADDR_W-1:0] mem_req_addr_o,
    input logic [ID_W-1:0]   mem_req_id_o,
    input logic              mem_rsp_valid_i,
    input logic              load_rsp_valid_o,
    input logic [ID_W-1:0]   load_rsp_id_o
);
    localparam int NUM_IDS = 1 << ID_W;

    logic [NUM_IDS-1:0] seen_q, seen_d;
    logic [ID_W-1:0]    sent_id_q;

    // Per-ID record of "retire strobe seen since this ID was last enqueued".
    always_comb begin
        seen_d = seen_q;
        if (enq_valid_i && enq_ready_o) seen_d[enq_id_i] = 1'b0;
        if (ret_valid_i)                seen_d[ret_id_i] = 1'b1;
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            seen_q    <= '0;
            sent_id_q <= '0;
        end else begin
            seen_q <= seen_d;
            if (mem_req_valid_o && mem_req_ready_i) sent_id_q <= mem_req_id_o;
        end
    end

    a_r4_periph_after_retire: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (mem_req_valid_o && ((mem_req_addr_o & PERIPH_MASK) == PERIPH_BASE)) |-> seen_q[mem_req_id_o]);

    a_r2_single_outstanding: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (mem_req_valid_o && mem_req_ready_i) |=> !mem_req_valid_o);

    a_r5_request_held: assert property (@(posedge clk_i) disable iff (!rst_ni || flush_i)
        (mem_req_valid_o && !mem_req_ready_i) |=>
            (mem_req_valid_o && $stable(mem_req_id_o) && $stable(mem_req_addr_o)));

    a_r7_no_request_in_flush: assert property (@(posedge clk_i) disable iff (!rst_ni)
        flush_i |-> !mem_req_valid_o);

    a_r10_no_enqueue_in_flush: assert property (@(posedge clk_i) disable iff (!rst_ni)
        flush_i |-> !enq_ready_o);

    a_r9_response_from_memory: assert property (@(posedge clk_i) disable iff (!rst_ni)
        load_rsp_valid_o |-> (mem_rsp_valid_i && (load_rsp_id_o == sent_id_q)));
endmodule

bind periph_load_gate plg_checker #(
    .ADDR_W      (ADDR_W),
    .ID_W        (ID_W),
    .PERIPH_BASE (PERIPH_BASE),
    .PERIPH_MASK (PERIPH_MASK)
) u_chk (
    .clk_i            (clk_i),
    .rst_ni           (rst_ni),
    .enq_valid_i      (enq_valid_i),
    .enq_id_i         (enq_id_i),
    .enq_ready_o      (enq_ready_o),
    .ret_valid_i      (ret_valid_i),
    .ret_id_i         (ret_id_i),
    .flush_i          (flush_i),
    .mem_req_valid_o  (mem_req_valid_o),
    .mem_req_ready_i  (mem_req_ready_i),
    .mem_req_addr_o   (mem_req_addr_o),
    .mem_req_id_o     (mem_req_id_o),
    .mem_rsp_valid_i  (mem_rsp_valid_i),
    .load_rsp_valid_o (load_rsp_valid_o),
    .load_rsp_id_o    (load_rsp_id_o)
);

// File: tb/periph_load_gate_tb.sv
module periph_load_gate_tb;
    localparam int ADDR_W = 32;
    localparam int ID_W   = 3;
    localparam int DATA_W = 32;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              enq_valid = 1'b0;
    logic [ID_W-1:0]   enq_id = '0;
    logic [ADDR_W-1:0] enq_addr = '0;
    logic              enq_ready;
    logic              ret_valid = 1'b0;
    logic [ID_W-1:0]   ret_id = '0;
    logic              flush = 1'b0;
    logic              req_valid;
    logic              req_ready = 1'b0;
    logic [ADDR_W-1:0] req_addr;
    logic [ID_W-1:0]   req_id;
    logic              rsp_valid = 1'b0;
    logic [DATA_W-1:0] rsp_data = '0;
    logic              ld_valid;
    logic [ID_W-1:0]   ld_id;
    logic [DATA_W-1:0] ld_data;

    int  nvec = 0;
    int  nerr = 0;
    bit  done = 1'b0;

    always #10 clk = ~clk;   // 50 MHz

    periph_load_gate u_dut (
        .clk_i            (clk),
        .rst_ni           (rst_n),
        .enq_valid_i      (enq_valid),
        .enq_id_i         (enq_id),
        .enq_addr_i       (enq_addr),
        .enq_ready_o      (enq_ready),
        .ret_valid_i      (ret_valid),
        .ret_id_i         (ret_id),
        .flush_i          (flush),
        .mem_req_valid_o  (req_valid),
        .mem_req_ready_i  (req_ready),
        .mem_req_addr_o   (req_addr),
        .mem_req_id_o     (req_id),
        .mem_rsp_valid_i  (rsp_valid),
        .mem_rsp_data_i   (rsp_data),
        .load_rsp_valid_o (ld_valid),
        .load_rsp_id_o    (ld_id),
        .load_rsp_data_o  (ld_data)
    );

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        nvec++;
        if (!ok) begin
            nerr++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic logic [DATA_W-1:0] data_of(input logic [ADDR_W-1:0] a);
        return a ^ 32'h5A5A_0000;
    endfunction

    // Called at a falling edge; returns at the next falling edge.
    task automatic enq(input logic [ID_W-1:0] id, input logic [ADDR_W-1:0] a, input string req);
        enq_valid = 1'b1; enq_id = id; enq_addr = a;
        #1 chk(enq_ready == 1'b1, req, enq_ready, 1);
        @(negedge clk);
        enq_valid = 1'b0;
    endtask

    task automatic retire(input logic [ID_W-1:0] id);
        ret_valid = 1'b1; ret_id = id;
        @(negedge clk);
        ret_valid = 1'b0;
    endtask

    // Expect a request, accept it, check the quiet cycle, return data.
    task automatic issue(input logic [ID_W-1:0] id, input logic [ADDR_W-1:0] a, input string req);
        #1;
        chk(req_valid == 1'b1, req, req_valid, 1);
        chk(req_id == id, req, req_id, id);
        chk(req_addr == a, req, req_addr, a);
        req_ready = 1'b1;
        @(negedge clk);
        req_ready = 1'b0;
        #1 chk(req_valid == 1'b0, "R2", req_valid, 0);
        rsp_valid = 1'b1; rsp_data = data_of(a);
        #1;
        chk(ld_valid == 1'b1, "R9", ld_valid, 1);
        chk(ld_id == id, "R9", ld_id, id);
        chk(ld_data == data_of(a), "R9", ld_data, data_of(a));
        @(negedge clk);
        rsp_valid = 1'b0;
    endtask

    task automatic no_req(input int n, input string req);
        for (int k = 0; k < n; k++) begin
            #1 chk(req_valid == 1'b0, req, req_valid, 0);
            @(negedge clk);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        #1;
        chk(req_valid == 1'b0, "R1", req_valid, 0);
        chk(ld_valid == 1'b0, "R1", ld_valid, 0);
        chk(enq_ready == 1'b1, "R1", enq_ready, 1);
        @(negedge clk);

        // R2: ordinary load issues without retire.
        enq(3'd1, 32'h0000_1000, "R2");
        issue(3'd1, 32'h0000_1000, "R2");

        // R9: response while idle is ignored.
        rsp_valid = 1'b1; rsp_data = 32'hDEAD_BEEF;
        #1 chk(ld_valid == 1'b0, "R9", ld_valid, 0);
        @(negedge clk);
        rsp_valid = 1'b0;

        // R4 / R5: device load held, younger ordinary load blocked behind it.
        enq(3'd2, 32'hF000_0020, "R4");
        enq(3'd3, 32'h0000_2000, "R5");
        no_req(3, "R5");
        ret_valid = 1'b1; ret_id = 3'd2;
        #1 chk(req_valid == 1'b0, "R4", req_valid, 0);
        @(negedge clk);
        ret_valid = 1'b0;
        issue(3'd2, 32'hF000_0020, "R4");
        issue(3'd3, 32'h0000_2000, "R5");

        // R4: retire in the enqueue cycle.
        ret_valid = 1'b1; ret_id = 3'd4;
        enq(3'd4, 32'hF000_0030, "R4");
        ret_valid = 1'b0;
        issue(3'd4, 32'hF000_0030, "R4");

        // R6: fill four device loads, refuse a fifth.
        for (int k = 0; k < 4; k++) enq(3'(4 + k), 32'hF000_0100 + 32'(k * 4), "R6");
        enq_valid = 1'b1; enq_id = 3'd0; enq_addr = 32'h0000_0100;
        #1 chk(enq_ready == 1'b0, "R6", enq_ready, 0);
        @(negedge clk);
        enq_valid = 1'b0;
        for (int k = 0; k < 4; k++) begin
            retire(3'(4 + k));
            issue(3'(4 + k), 32'hF000_0100 + 32'(k * 4), "R5");
        end
        no_req(3, "R6");
        #1 chk(enq_ready == 1'b1, "R6", enq_ready, 1);
        @(negedge clk);

        // R7 / R8 / R10: flush with a retired head stalled by memory.
        ret_valid = 1'b1; ret_id = 3'd1;
        enq(3'd1, 32'hF000_0200, "R8");
        ret_valid = 1'b0;
        #1 chk(req_valid == 1'b1, "R8", req_valid, 1);
        enq(3'd2, 32'hF000_0204, "R7");
        enq(3'd3, 32'h0000_0300, "R7");
        flush = 1'b1;
        enq_valid = 1'b1; enq_id = 3'd5; enq_addr = 32'h0000_0500;
        #1;
        chk(req_valid == 1'b0, "R7", req_valid, 0);
        chk(enq_ready == 1'b0, "R10", enq_ready, 0);
        @(negedge clk);
        flush = 1'b0; enq_valid = 1'b0;
        issue(3'd1, 32'hF000_0200, "R8");
        retire(3'd2);
        no_req(4, "R7");

        // R3: sweep of the top nibble at two low offsets.
        for (int nib = 0; nib < 16; nib++) begin
            for (int lo = 0; lo < 2; lo++) begin
                logic [ADDR_W-1:0] a;
                logic [ID_W-1:0]   id;
                bit                per;
                a   = {4'(nib), (lo == 0) ? 28'h000_0040 : 28'hFFF_FFFC};
                id  = 3'((nib * 2 + lo) % 8);
                per = (nib == 15);
                enq(id, a, "R3");
                #1 chk(req_valid == !per, "R3", req_valid, !per);
                if (!per) begin
                    issue(id, a, "R3");
                end else begin
                    flush = 1'b1;
                    @(negedge clk);
                    flush = 1'b0;
                    no_req(2, "R3");
                end
            end
        end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
        $finish;
    end

    initial begin
        #(20 * 100000);
        if (!done) begin
            nvec++;
            nerr++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
            $finish;
        end
    end
endmodule